// File: doc/BRIEF.md
# Two-Pipe Layer Compositor

This block merges up to four rectangular picture layers into a single RGB pixel stream. Every layer has a rectangle on the screen (origin and size), an enable, a pipe select, a priority and an optional global alpha, all loaded through a simple word-write port. The caller presents the raster coordinates of one output pixel together with the ARGB sample of every layer at that position. Three clocks later the block produces the composed RGB value, and a valid flag travels with the pixel through the pipeline.

Composition runs in two steps. First, each of the two pipes keeps only its highest-priority layer that covers the pixel. Second, the pipe-1 survivor is alpha-blended over the pipe-0 survivor. Pixels that no layer covers, and pixels outside the programmed display area, take the background color. An optional compatibility mode reproduces a known flaw: a translucent layer at the bottom of pipe 0 shows the background instead of its own data.

Top module: `layer_compositor`

## Requirements
- R1: After reset, out_valid is 0 and out_rgb is 0. The background color resets to black, so a scene with no enabled layer outputs 0x000000.
- R2: Each cycle with in_valid high produces exactly one cycle with out_valid high, 3 clock edges later and in the same order. out_valid is low in every other cycle.
- R3: A layer covers (x,y) when ox <= x < ox+w and oy <= y < oy+h. A pixel that no enabled layer covers outputs the background color.
- R4: A layer whose enable bit is 0 never contributes to the output, whatever its priority.
- R5: Within one pipe, the covering layer with the largest priority value supplies that pipe's pixel.
- R6: When covering layers in one pipe have equal priority, the layer with the lower index wins.
- R7: Each channel of the output is (a*P1 + (255-a)*P0 + 127)/255, where a is the effective alpha of the pipe-1 winner. P0 is the RGB of the pipe-0 winner, or the background color when pipe 0 has no winner, and the alpha of pipe 0 is ignored. With no pipe-1 winner the output is P0. In lay_pix, the sample of layer l sits at bits [32l+31:32l] as A[31:24], R[23:16], G[15:8], B[7:0].
- R8: With the global-alpha enable set, the effective alpha is (A*G+127)/255, where G is the global alpha. With the enable clear, the global alpha counts as opaque and the effective alpha is A.
- R9: With the compatibility bit set, if the pipe-0 winner has priority 0 and an effective alpha other than 255, the background color replaces P0. With the bit clear, that layer's RGB is used.
- R10: A pixel with x >= display width or y >= display height outputs the background color. The display size resets to 0.
- R11: Register writes take effect on the clock edge where cfg_we is high. Word 0 holds the display size: width in [COORD_W-1:0] and height in [16+COORD_W-1:16]. Word 1 holds the background RGB in [23:0]. Word 2 holds the compatibility bit in [0]. For layer l, word 4+4l holds the size (w, h in the same fields as word 0), word 5+4l holds the origin (x, y in the same fields), and word 6+4l holds the attributes: enable [0], pipe [1], global-alpha enable [2], global alpha [15:8] and priority [16+PRIO_W-1:16].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Register word address |
| cfg_wdata | input | 32 | Register write data |
| in_valid | input | 1 | Raster position and layer samples are valid |
| ras_x | input | COORD_W | Raster column |
| ras_y | input | COORD_W | Raster row |
| lay_pix | input | 32*NUM_LAYERS | ARGB sample of every layer at this position |
| out_valid | output | 1 | Composed pixel is valid |
| out_rgb | output | 24 | Composed RGB pixel |

## Verification
The compatibility replacement of the pipe-0 pixel and the pipe-1 blend can both act on the same pixel. The bench provokes this with a translucent priority-0 layer in pipe 0 and a partly transparent layer in pipe 1 covering the same rectangle, and runs the scene with the compatibility bit set and then cleared. The scoreboard predicts every pixel independently: with the bit set, the pipe-1 layer must blend over the background color, and with it clear, over the pipe-0 data. Either a missing replacement or a replacement that skips the blend shows up as a miscompare.

// File: rtl/lcomp_pkg.sv
package lcomp_pkg;

   // Normalised 8x8 product: (x*y + 127) / 255
   function automatic logic [7:0] mul_norm(input logic [7:0] x, input logic [7:0] y);
      logic [16:0] s;
      s = 17'(x) * 17'(y) + 17'd127;
      return 8'(s / 17'd255);
   endfunction

   // One channel of foreground-over-background mixing
   function automatic logic [7:0] mix8(input logic [7:0] a, input logic [7:0] fg,
                                       input logic [7:0] bg);
      logic [16:0] s;
      s = 17'(a) * 17'(fg) + 17'(8'd255 - a) * 17'(bg) + 17'd127;
      return 8'(s / 17'd255);
   endfunction

endpackage

// File: rtl/lcomp_regs.sv
module lcomp_regs #(
   parameter int NL = 4,
   parameter int CW = 12,
   parameter int PW = 2,
   parameter int AW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [31:0]   wdata,
   output logic [CW-1:0] disp_w,
   output logic [CW-1:0] disp_h,
   output logic [23:0]   bg,
   output logic          quirk,
   output logic [CW-1:0] lx [NL],
   output logic [CW-1:0] ly [NL],
   output logic [CW-1:0] lw [NL],
   output logic [CW-1:0] lh [NL],
   output logic          en [NL],
   output logic          pipe [NL],
   output logic          gen [NL],
   output logic [7:0]    ga [NL],
   output logic [PW-1:0] pri [NL]
);
   wire unused_wbits = ^wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         disp_w <= '0;
         disp_h <= '0;
         bg     <= '0;
         quirk  <= 1'b0;
      end else if (we) begin
         case (addr)
            AW'(0): begin
               disp_w <= wdata[CW-1:0];
               disp_h <= wdata[16 +: CW];
            end
            AW'(1): bg    <= wdata[23:0];
            AW'(2): quirk <= wdata[0];
            default: ;
         endcase
      end
   end

   for (genvar l = 0; l < NL; l++) begin : g_lay
      localparam logic [AW-1:0] BASE = AW'(4 * (l + 1));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lx[l]   <= '0;
            ly[l]   <= '0;
            lw[l]   <= '0;
            lh[l]   <= '0;
            en[l]   <= 1'b0;
            pipe[l] <= 1'b0;
            gen[l]  <= 1'b0;
            ga[l]   <= '0;
            pri[l]  <= '0;
         end else if (we) begin
            if (addr == BASE) begin
               lw[l] <= wdata[CW-1:0];
               lh[l] <= wdata[16 +: CW];
            end
            if (addr == BASE + AW'(1)) begin
               lx[l] <= wdata[CW-1:0];
               ly[l] <= wdata[16 +: CW];
            end
            if (addr == BASE + AW'(2)) begin
               en[l]   <= wdata[0];
               pipe[l] <= wdata[1];
               gen[l]  <= wdata[2];
               ga[l]   <= wdata[15:8];
               pri[l]  <= wdata[16 +: PW];
            end
         end
      end
   end
endmodule

// File: rtl/lcomp_cover.sv
module lcomp_cover
   import lcomp_pkg::*;
#(
   parameter int CW = 12
) (
   input  logic [CW-1:0] x,
   input  logic [CW-1:0] y,
   input  logic [CW-1:0] ox,
   input  logic [CW-1:0] oy,
   input  logic [CW-1:0] w,
   input  logic [CW-1:0] h,
   input  logic          en,
   input  logic [7:0]    pa,
   input  logic [7:0]    ga,
   input  logic          gen,
   output logic          hit,
   output logic [7:0]    eff_a
);
   logic [CW:0] x_end, y_end;

   assign x_end = {1'b0, ox} + {1'b0, w};
   assign y_end = {1'b0, oy} + {1'b0, h};
   assign hit   = en && (x >= ox) && ({1'b0, x} < x_end)
                     && (y >= oy) && ({1'b0, y} < y_end);
   assign eff_a = gen ? mul_norm(pa, ga) : pa;
endmodule

// File: rtl/lcomp_pick.sv
module lcomp_pick #(
   parameter int NL  = 4,
   parameter int PW  = 2,
   parameter bit SEL = 1'b0,
   localparam int IW = (NL > 1) ? $clog2(NL) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hit [NL],
   input  logic          pipe [NL],
   input  logic [PW-1:0] pri [NL],
   output logic          win_vld,
   output logic [IW-1:0] win_idx,
   output logic [PW-1:0] win_pri
);
   always_comb begin
      win_vld = 1'b0;
      win_idx = '0;
      win_pri = '0;
      for (int i = 0; i < NL; i++) begin
         if (hit[i] && (pipe[i] == SEL) && (!win_vld || (pri[i] > win_pri))) begin
            win_vld = 1'b1;
            win_idx = IW'(i);
            win_pri = pri[i];
         end
      end
   end

   for (genvar i = 0; i < NL; i++) begin : g_chk
      // R5
      win_pri_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (hit[i] && (pipe[i] == SEL)) |-> (win_vld && (win_pri >= pri[i])));
      // R6
      win_tie_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (hit[i] && (pipe[i] == SEL) && (pri[i] == win_pri)) |-> (win_idx <= IW'(i)));
   end
endmodule

// File: rtl/lcomp_blend.sv
module lcomp_blend
   import lcomp_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        vld_i,
   input  logic [7:0]  a_i,
   input  logic [23:0] fg_i,
   input  logic [23:0] bg_i,
   output logic        vld_o,
   output logic [23:0] rgb_o
);
   logic [23:0] mix_c;

   for (genvar c = 0; c < 3; c++) begin : g_ch
      assign mix_c[8*c +: 8] = mix8(a_i, fg_i[8*c +: 8], bg_i[8*c +: 8]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_o <= 1'b0;
         rgb_o <= '0;
      end else begin
         vld_o <= vld_i;
         rgb_o <= vld_i ? mix_c : rgb_o;
      end
   end

   // R7
   blend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_i && (a_i == 8'd0)) |=> (rgb_o == $past(bg_i)));
   // R7
   blend_solid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_i && (a_i == 8'd255)) |=> (rgb_o == $past(fg_i)));
endmodule

// File: rtl/layer_compositor.sv
module layer_compositor #(
   parameter int NUM_LAYERS = 4,
   parameter int COORD_W    = 12,
   parameter int PRIO_W     = 2,
   localparam int ADDR_W    = $clog2(4 * (NUM_LAYERS + 1))
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cfg_we,
   input  logic [ADDR_W-1:0]       cfg_addr,
   input  logic [31:0]             cfg_wdata,
   input  logic                    in_valid,
   input  logic [COORD_W-1:0]      ras_x,
   input  logic [COORD_W-1:0]      ras_y,
   input  logic [32*NUM_LAYERS-1:0] lay_pix,
   output logic                    out_valid,
   output logic [23:0]             out_rgb
);
   localparam int NL = NUM_LAYERS;
   localparam int IW = (NL > 1) ? $clog2(NL) : 1;

   if (NL < 2 || NL > 8) begin : g_bad_nl
      $error("NUM_LAYERS must lie in 2..8");
   end
   if (COORD_W < 2 || COORD_W > 16) begin : g_bad_cw
      $error("COORD_W must lie in 2..16");
   end
   if (PRIO_W < 1 || PRIO_W > 8) begin : g_bad_pw
      $error("PRIO_W must lie in 1..8");
   end

   // configuration
   logic [COORD_W-1:0] disp_w, disp_h;
   logic [23:0]        bg;
   logic               quirk;
   logic [COORD_W-1:0] lx [NL], ly [NL], lw [NL], lh [NL];
   logic               en [NL], pipe [NL], gen [NL];
   logic [7:0]         ga [NL];
   logic [PRIO_W-1:0]  pri [NL];

   lcomp_regs #(.NL(NL), .CW(COORD_W), .PW(PRIO_W), .AW(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
      .disp_w(disp_w), .disp_h(disp_h), .bg(bg), .quirk(quirk),
      .lx(lx), .ly(ly), .lw(lw), .lh(lh), .en(en), .pipe(pipe), .gen(gen),
      .ga(ga), .pri(pri)
   );

   // stage 1: coverage and effective alpha
   logic       hit_c [NL];
   logic [7:0] ea_c [NL];
   logic       in_disp;

   for (genvar l = 0; l < NL; l++) begin : g_cov
      lcomp_cover #(.CW(COORD_W)) u_cov (
         .x(ras_x), .y(ras_y), .ox(lx[l]), .oy(ly[l]), .w(lw[l]), .h(lh[l]),
         .en(en[l]), .pa(lay_pix[32*l+24 +: 8]), .ga(ga[l]), .gen(gen[l]),
         .hit(hit_c[l]), .eff_a(ea_c[l])
      );
   end

   assign in_disp = (ras_x < disp_w) && (ras_y < disp_h);

   logic        s1_vld;
   logic        s1_hit [NL];
   logic [7:0]  s1_a [NL];
   logic [23:0] s1_rgb [NL];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_vld <= 1'b0;
         for (int l = 0; l < NL; l++) begin
            s1_hit[l] <= 1'b0;
            s1_a[l]   <= '0;
            s1_rgb[l] <= '0;
         end
      end else begin
         s1_vld <= in_valid;
         for (int l = 0; l < NL; l++) begin
            s1_hit[l] <= in_valid && in_disp && hit_c[l];
            s1_a[l]   <= ea_c[l];
            s1_rgb[l] <= lay_pix[32*l +: 24];
         end
      end
   end

   // stage 2: per-pipe priority pick
   logic              w_vld [2];
   logic [IW-1:0]     w_idx [2];
   logic [PRIO_W-1:0] w_pri [2];

   for (genvar p = 0; p < 2; p++) begin : g_pipe
      lcomp_pick #(.NL(NL), .PW(PRIO_W), .SEL(p[0])) u_pick (
         .clk(clk), .rst_n(rst_n), .hit(s1_hit), .pipe(pipe), .pri(pri),
         .win_vld(w_vld[p]), .win_idx(w_idx[p]), .win_pri(w_pri[p])
      );
   end

   logic [23:0] p0_rgb_c, p1_rgb_c;
   logic [7:0]  p1_a_c;
   logic        p0_drop;

   always_comb begin
      p0_drop  = quirk && (w_pri[0] == '0) && (s1_a[w_idx[0]] != 8'hFF);
      p0_rgb_c = (w_vld[0] && !p0_drop) ? s1_rgb[w_idx[0]] : bg;
      p1_rgb_c = w_vld[1] ? s1_rgb[w_idx[1]] : 24'h0;
      p1_a_c   = w_vld[1] ? s1_a[w_idx[1]] : 8'h00;
   end

   logic        s2_vld;
   logic [23:0] s2_p0, s2_p1;
   logic [7:0]  s2_a;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s2_vld <= 1'b0;
         s2_p0  <= '0;
         s2_p1  <= '0;
         s2_a   <= '0;
      end else begin
         s2_vld <= s1_vld;
         s2_p0  <= p0_rgb_c;
         s2_p1  <= p1_rgb_c;
         s2_a   <= p1_a_c;
      end
   end

   // stage 3: pipe blend
   lcomp_blend u_blend (
      .clk(clk), .rst_n(rst_n), .vld_i(s2_vld), .a_i(s2_a),
      .fg_i(s2_p1), .bg_i(s2_p0), .vld_o(out_valid), .rgb_o(out_rgb)
   );

   logic [1:0] since_rst;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  since_rst <= '0;
      else if (since_rst != 2'd3)  since_rst <= since_rst + 2'd1;
   end

   // R2
   out_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3)));
endmodule

// File: tb/layer_compositor_tb_top.sv
module layer_compositor_tb_top;
   localparam int NL = 4;
   localparam int CW = 12;
   localparam int AW = $clog2(4 * (NL + 1));

   logic            clk = 1'b0;
   logic            rst_n;
   logic            cfg_we;
   logic [AW-1:0]   cfg_addr;
   logic [31:0]     cfg_wdata;
   logic            in_valid;
   logic [CW-1:0]   ras_x, ras_y;
   logic [32*NL-1:0] lay_pix;
   logic            out_valid;
   logic [23:0]     out_rgb;

   always #2 clk = ~clk;

   layer_compositor #(.NUM_LAYERS(NL), .COORD_W(CW), .PRIO_W(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .in_valid(in_valid), .ras_x(ras_x), .ras_y(ras_y),
      .lay_pix(lay_pix), .out_valid(out_valid), .out_rgb(out_rgb)
   );

   // bench copy of the programmed scene
   int        dw, dh;
   logic [23:0] bgc;
   bit        quirk;
   int        lx[NL], ly[NL], lw[NL], lh[NL], ga[NL], pr[NL];
   bit        en[NL], pp[NL], ge[NL];
   logic [8:0] afix[NL];

   int n_chk = 0, n_bad = 0, cyc = 0;
   bit done = 1'b0;

   typedef struct { logic [23:0] rgb; int due; string tag; } exp_t;
   exp_t q[$];

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] gen_pix(int l, int x, int y);
      logic [7:0] a;
      a = afix[l][8] ? afix[l][7:0] : 8'((x * 37 + y * 11 + l * 53) & 255);
      return {a, 8'(x * 17 + l * 61 + y * 3), 8'(y * 29 + l * 7 + x), 8'(x * y + l * 91)};
   endfunction

   function automatic int nrm(int a, int b);
      return (a * b + 127) / 255;
   endfunction

   function automatic int mixc(int a, int f, int b);
      return (a * f + (255 - a) * b + 127) / 255;
   endfunction

   function automatic logic [23:0] exp_pix(int x, int y);
      int win[2], wp[2], ea[NL], a;
      logic [31:0] px, fp;
      logic [23:0] c0;
      if (x >= dw || y >= dh) return bgc;          // R10
      win[0] = -1; win[1] = -1; wp[0] = 0; wp[1] = 0;
      for (int l = 0; l < NL; l++) begin
         px = gen_pix(l, x, y);
         ea[l] = ge[l] ? nrm(int'(px[31:24]), ga[l]) : int'(px[31:24]);   // R8
         if (en[l] && x >= lx[l] && x < lx[l] + lw[l] && y >= ly[l] && y < ly[l] + lh[l]) begin
            if (win[pp[l]] < 0 || pr[l] > wp[pp[l]]) begin
               win[pp[l]] = l;
               wp[pp[l]] = pr[l];
            end
         end
      end
      c0 = bgc;
      if (win[0] >= 0 && !(quirk && wp[0] == 0 && ea[win[0]] != 255)) begin
         px = gen_pix(win[0], x, y);
         c0 = px[23:0];
      end
      if (win[1] < 0) return c0;
      fp = gen_pix(win[1], x, y);
      a = ea[win[1]];
      return {8'(mixc(a, int'(fp[23:16]), int'(c0[23:16]))),
              8'(mixc(a, int'(fp[15:8]),  int'(c0[15:8]))),
              8'(mixc(a, int'(fp[7:0]),   int'(c0[7:0])))};
   endfunction

   task automatic wr(int addr, logic [31:0] data);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = AW'(addr); cfg_wdata = data;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // R11: field positions of the size, origin and attribute words
   task automatic set_layer(int l, int x, int y, int w, int h, bit e, bit p,
                            int pri, bit g_en, int g);
      lx[l] = x; ly[l] = y; lw[l] = w; lh[l] = h;
      en[l] = e; pp[l] = p; pr[l] = pri; ge[l] = g_en; ga[l] = g;
      wr(4 + 4 * l, (32'(h) << 16) | 32'(w));
      wr(5 + 4 * l, (32'(y) << 16) | 32'(x));
      wr(6 + 4 * l, 32'(e) | (32'(p) << 1) | (32'(g_en) << 2) | (32'(g) << 8) | (32'(pri) << 16));
   endtask

   task automatic set_disp(int w, int h);
      dw = w; dh = h;
      wr(0, (32'(h) << 16) | 32'(w));
   endtask

   task automatic run_frame(string tag, int w, int h);
      exp_t e;
      for (int y = 0; y < h; y++) begin
         for (int x = 0; x < w; x++) begin
            @(negedge clk);
            in_valid = 1'b1; ras_x = CW'(x); ras_y = CW'(y);
            for (int l = 0; l < NL; l++) lay_pix[32*l +: 32] = gen_pix(l, x, y);
            e.rgb = exp_pix(x, y); e.due = cyc + 3; e.tag = tag;
            q.push_back(e);
         end
      end
      @(negedge clk);
      in_valid = 1'b0;
      repeat (6) @(negedge clk);
      chk(q.size() == 0, "R2 drain", 32'(q.size()), 32'd0);
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         if (q.size() > 0 && q[0].due < cyc) begin
            chk(1'b0, "R2 missing output", 32'(cyc), 32'(q[0].due));
            void'(q.pop_front());
         end
         if (out_valid) begin
            if (q.size() == 0) begin
               chk(1'b0, "R2 unexpected output", 32'(out_rgb), 32'd0);
            end else begin
               exp_t e;
               e = q.pop_front();
               chk(cyc == e.due, "R2 latency", 32'(cyc), 32'(e.due));
               chk(out_rgb == e.rgb, e.tag, 32'(out_rgb), 32'(e.rgb));
            end
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #600000;
      chk(1'b0, "watchdog", 32'(cyc), 32'd0);
      finish_run();
   end

   initial begin
      rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
      in_valid = 1'b0; ras_x = '0; ras_y = '0; lay_pix = '0;
      dw = 0; dh = 0; bgc = 24'h0; quirk = 1'b0;
      for (int l = 0; l < NL; l++) begin
         lx[l] = 0; ly[l] = 0; lw[l] = 0; lh[l] = 0; ga[l] = 0; pr[l] = 0;
         en[l] = 0; pp[l] = 0; ge[l] = 0; afix[l] = 9'h1FF;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(out_valid == 1'b0, "R1 out_valid", 32'(out_valid), 32'd0);
      chk(out_rgb == 24'h0, "R1 out_rgb", 32'(out_rgb), 32'd0);

      // R10 display size resets to 0: all background
      run_frame("R10 zero display", 4, 3);
      set_disp(16, 12);
      run_frame("R1 empty scene black", 16, 12);

      bgc = 24'h203040; wr(1, 32'(bgc));
      // R3 single opaque rectangle
      set_layer(0, 3, 2, 6, 5, 1, 0, 1, 0, 0);
      run_frame("R3 coverage", 16, 12);

      // R5 higher priority wins in pipe 0
      set_layer(1, 5, 4, 8, 6, 1, 0, 2, 0, 0);
      run_frame("R5 priority", 16, 12);

      // R6 equal priority: lower index
      set_layer(1, 5, 4, 8, 6, 1, 0, 1, 0, 0);
      run_frame("R6 tie", 16, 12);

      // R4 disabled layer with top priority
      set_layer(1, 0, 0, 16, 12, 0, 0, 3, 0, 0);
      run_frame("R4 disabled", 16, 12);

      // R7 pipe-1 layers: varying alpha, plus a fully clear and a solid one
      afix[2] = 9'h0FF & 9'h000;
      set_layer(2, 2, 1, 10, 8, 1, 1, 0, 0, 0);
      afix[3] = 9'h100;
      set_layer(3, 10, 6, 5, 5, 1, 1, 3, 0, 0);
      run_frame("R7 blend clear", 16, 12);
      afix[3] = 9'h1FF;
      run_frame("R7 blend solid", 16, 12);

      // R8 global alpha on the pipe-1 layer
      set_layer(2, 2, 1, 10, 8, 1, 1, 0, 1, 8'h80);
      run_frame("R8 global alpha", 16, 12);
      set_layer(2, 2, 1, 10, 8, 1, 1, 0, 0, 8'h10);
      run_frame("R8 global alpha off", 16, 12);

      // R9 translucent bottom layer in pipe 0, blended over by pipe 1
      afix[0] = 9'h0FF & 9'h000;
      set_layer(0, 1, 1, 12, 9, 1, 0, 0, 0, 0);
      set_layer(3, 0, 0, 0, 0, 0, 1, 3, 0, 0);
      quirk = 1'b1; wr(2, 32'd1);
      run_frame("R9 compat on", 16, 12);
      quirk = 1'b0; wr(2, 32'd0);
      run_frame("R9 compat off", 16, 12);
      quirk = 1'b1; wr(2, 32'd1);
      set_layer(0, 1, 1, 12, 9, 1, 0, 2, 0, 0);
      run_frame("R9 compat nonzero priority", 16, 12);

      // R10 display smaller than the raster
      set_disp(9, 7);
      run_frame("R10 outside display", 16, 12);

      repeat (4) @(negedge clk);
      finish_run();
   end
endmodule